// File: doc/BRIEF.md
# Decoded RAM/ROM Memory Subsystem

This block is the memory a small processor sees on a 10-bit address bus. It holds four read/write banks of 128 bytes each and one read-only bank of 512 bytes. A decoder uses the upper address bits to pick exactly one bank. Each bank has a pair of chip selects, one active high and one active low. A bank works only when the active-high select is 1 and the active-low select is 0.

The processor drives an address, a read strobe, a write strobe and write data. Reads are combinational: the addressed byte appears on `rd_data` in the same cycle as the strobe. Writes take effect on the rising clock edge. A shared tri-state data bus is modelled as a data vector plus a valid flag. When no bank is driving, the data vector is zero and the flag is low. The read-only contents are fixed by a formula computed inside the RTL.

Top module: `mem_subsys`

## Requirements
- R1: Address bit 9 set to 1 selects the read-only bank at offset addr[8:0]. Address bit 9 clear selects RAM bank addr[8:7] (0 to 3) at offset addr[6:0], so the banks sit at 0x000, 0x080, 0x100 and 0x180.
- R2: A bank is active only when its active-high select is 1 and its active-low select is 0. At most one bank drives the read data in any cycle.
- R3: With a bank selected, rd=1 performs a read whatever wr is. `rd_valid` is 1 and `rd_data` shows the addressed byte in the same cycle, and no write takes place.
- R4: rd=0 with wr=1 stores `wdata` into the addressed RAM byte on the rising clock edge.
- R5: rd=0 with wr=0 does nothing: no write, `rd_valid`=0.
- R6: Whenever no bank performs a read, `rd_valid` is 0 and `rd_data` is 8'h00, which stands for high impedance.
- R7: The read-only byte at offset k equals k[7:0] XOR (k[8] ? 8'hFF : 8'h00).
- R8: A write to an address with bit 9 set is ignored. No RAM bank changes and the read-only data is unchanged.
- R9: The RAM banks are independent. A write to one bank leaves the same offset in the other three banks unchanged.
- R10: While `rst` is 1, write strobes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes occur on its rising edge |
| rst | input | 1 | Synchronous active-high reset; blocks writes |
| addr | input | 10 | Processor address |
| rd | input | 1 | Read strobe (wins over wr) |
| wr | input | 1 | Write strobe |
| wdata | input | 8 | Write data |
| rd_data | output | 8 | Read data, zero when nothing drives |
| rd_valid | output | 1 | Bus-drive flag, high when a bank is read |

## Verification
Some rules are checked by assertions on every cycle:
- at most one bank drives the bus;
- the valid flag is high exactly when a read strobe is present;
- the read-only bank drives only for addresses with bit 9 set;
- each accepted RAM write lands in storage by the next cycle.

Other behaviour shows only in the bench's scenarios, because it needs knowledge of the data:
- the expected read-only bytes;
- bank isolation at equal offsets;
- writes ignored in the read-only range or during reset;
- read winning over a simultaneous write.

// File: rtl/mem_subsys_pkg.sv
package mem_subsys_pkg;

    localparam int ADDR_W  = 10;
    localparam int DATA_W  = 8;
    localparam int RAM_AW  = 7;
    localparam int NUM_RAM = 4;
    localparam int ROM_AW  = ADDR_W - 1;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } bank_op_t;

    // Two-select control table: only sel_hi=1, sel_lo=0 enables; read wins.
    function automatic bank_op_t decode_op(input logic sel_hi, input logic sel_lo,
                                           input logic rd, input logic wr);
        if (!(sel_hi && !sel_lo)) return OP_IDLE;
        if (rd)                   return OP_READ;
        if (wr)                   return OP_WRITE;
        return OP_IDLE;
    endfunction

    // Fixed read-only image, computed from the offset.
    function automatic logic [DATA_W-1:0] rom_byte(input logic [ROM_AW-1:0] k);
        return k[7:0] ^ {8{k[8]}};
    endfunction

endpackage

// File: rtl/msub_bank_sel.sv
module msub_bank_sel
    import mem_subsys_pkg::*;
#(
    parameter int AW     = ADDR_W,
    parameter int N_RAM  = NUM_RAM,
    parameter int RAM_W  = RAM_AW
) (
    input  logic [AW-1:0]    addr,
    output logic [N_RAM-1:0] ram_sel_hi,
    output logic [N_RAM-1:0] ram_sel_lo,
    output logic             rom_sel_hi,
    output logic             rom_sel_lo
);
    localparam int SEL_W = $clog2(N_RAM);

    logic [SEL_W-1:0] grp;
    logic             rom_zone;

    assign rom_zone = addr[AW-1];
    assign grp      = addr[RAM_W +: SEL_W];

    // Active-low select of every RAM bank follows the read-only zone line.
    for (genvar i = 0; i < N_RAM; i++) begin : g_dec
        assign ram_sel_hi[i] = (grp == SEL_W'(i));
        assign ram_sel_lo[i] = rom_zone;
    end

    assign rom_sel_hi = rom_zone;
    assign rom_sel_lo = 1'b0;

    initial begin
        assert (RAM_W + SEL_W == AW - 1)
            else $error("bank decoder address widths do not fit");
    end
endmodule

// File: rtl/msub_ram_bank.sv
module msub_ram_bank
    import mem_subsys_pkg::*;
#(
    parameter int AW = RAM_AW,
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          sel_hi,
    input  logic          sel_lo,
    input  logic          rd,
    input  logic          wr,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    output logic          drive
);
    localparam int DEPTH = 2 ** AW;

    bank_op_t      op;
    logic [DW-1:0] mem [DEPTH];

    assign op = decode_op(sel_hi, sel_lo, rd, wr);

    always_ff @(posedge clk) begin
        if (!rst && op == OP_WRITE) begin
            mem[addr] <= wdata;
        end
    end

    assign drive = (op == OP_READ);
    assign rdata = drive ? mem[addr] : '0;

    // R4: an accepted write is held in storage one cycle later
    assert_write_lands_R4: assert property (@(posedge clk) disable iff (rst)
        (op == OP_WRITE) |=> (mem[$past(addr)] == $past(wdata)));
endmodule

// File: rtl/msub_rom_bank.sv
module msub_rom_bank
    import mem_subsys_pkg::*;
#(
    parameter int AW = ROM_AW,
    parameter int DW = DATA_W
) (
    input  logic          sel_hi,
    input  logic          sel_lo,
    input  logic          rd,
    input  logic [AW-1:0] addr,
    output logic [DW-1:0] rdata,
    output logic          drive
);
    bank_op_t op;

    // Write strobe is tied low: this bank has no storage path.
    assign op    = decode_op(sel_hi, sel_lo, rd, 1'b0);
    assign drive = (op == OP_READ);
    assign rdata = drive ? rom_byte(addr) : '0;
endmodule

// File: rtl/mem_subsys.sv
module mem_subsys
    import mem_subsys_pkg::*;
#(
    parameter int AW    = ADDR_W,
    parameter int DW    = DATA_W,
    parameter int RAW   = RAM_AW,
    parameter int N_RAM = NUM_RAM
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] addr,
    input  logic          rd,
    input  logic          wr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rd_data,
    output logic          rd_valid
);
    localparam int RO_W = AW - 1;

    logic [N_RAM-1:0] ram_hi, ram_lo, ram_drv;
    logic             rom_hi, rom_lo, rom_drv;
    logic [DW-1:0]    ram_q [N_RAM];
    logic [DW-1:0]    rom_q;
    logic [N_RAM:0]   all_drv;

    msub_bank_sel #(.AW(AW), .N_RAM(N_RAM), .RAM_W(RAW)) u_sel (
        .addr       (addr),
        .ram_sel_hi (ram_hi),
        .ram_sel_lo (ram_lo),
        .rom_sel_hi (rom_hi),
        .rom_sel_lo (rom_lo)
    );

    for (genvar i = 0; i < N_RAM; i++) begin : g_ram
        msub_ram_bank #(.AW(RAW), .DW(DW)) u_ram (
            .clk    (clk),
            .rst    (rst),
            .sel_hi (ram_hi[i]),
            .sel_lo (ram_lo[i]),
            .rd     (rd),
            .wr     (wr),
            .addr   (addr[RAW-1:0]),
            .wdata  (wdata),
            .rdata  (ram_q[i]),
            .drive  (ram_drv[i])
        );
    end

    msub_rom_bank #(.AW(RO_W), .DW(DW)) u_rom (
        .sel_hi (rom_hi),
        .sel_lo (rom_lo),
        .rd     (rd),
        .addr   (addr[RO_W-1:0]),
        .rdata  (rom_q),
        .drive  (rom_drv)
    );

    // Wired bus: undriven banks contribute zero.
    always_comb begin
        rd_data = rom_q;
        for (int i = 0; i < N_RAM; i++) begin
            rd_data = rd_data | ram_q[i];
        end
    end

    assign all_drv  = {rom_drv, ram_drv};
    assign rd_valid = |all_drv;

    assert_one_driver_R2: assert property (@(posedge clk) disable iff (rst)
        $onehot0(all_drv));
    assert_read_drives_R3: assert property (@(posedge clk) disable iff (rst)
        rd |-> rd_valid);
    assert_quiet_bus_R6: assert property (@(posedge clk) disable iff (rst)
        !rd |-> (!rd_valid && rd_data == '0));
    assert_rom_zone_R1: assert property (@(posedge clk) disable iff (rst)
        rom_drv |-> addr[AW-1]);
endmodule

// File: tb/mem_subsys_bench.sv
module mem_subsys_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [9:0] addr = '0;
    logic       rd = 1'b0;
    logic       wr = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rd_data;
    logic       rd_valid;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    mem_subsys u_mem_subsys (
        .clk(clk), .rst(rst), .addr(addr), .rd(rd), .wr(wr),
        .wdata(wdata), .rd_data(rd_data), .rd_valid(rd_valid)
    );

    function automatic logic [7:0] exp_rom(input logic [8:0] k);
        return k[7:0] ^ (k[8] ? 8'hFF : 8'h00);
    endfunction

    task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [9:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr = 1'b1; rd = 1'b0;
        @(negedge clk);
        wr = 1'b0;
    endtask

    // Read at negedge, sample 1 ns later; returns {valid, data}.
    task automatic do_read(input logic [9:0] a, output logic [8:0] got);
        @(negedge clk);
        addr = a; rd = 1'b1; wr = 1'b0;
        #1 got = {rd_valid, rd_data};
        @(negedge clk);
        rd = 1'b0;
    endtask

    task automatic t_reset_state;
        repeat (2) @(negedge clk);
        #1 check("R6 reset idle bus", {rd_valid, rd_data}, 9'h000);
        rst = 1'b0;
    endtask

    task automatic t_ram_rw;
        logic [8:0] g;
        do_write(10'h000, 8'hA1);
        do_write(10'h07F, 8'hB2);
        do_write(10'h0C5, 8'hC3);
        do_write(10'h1FF, 8'hD4);
        do_read(10'h000, g); check("R4 bank0 low", g, {1'b1, 8'hA1});
        do_read(10'h07F, g); check("R4 bank0 top", g, {1'b1, 8'hB2});
        do_read(10'h0C5, g); check("R1 bank1", g, {1'b1, 8'hC3});
        do_read(10'h1FF, g); check("R1 bank3 top", g, {1'b1, 8'hD4});
    endtask

    task automatic t_bank_isolation;
        logic [8:0] g;
        for (int b = 0; b < 4; b++) do_write(10'((b << 7) | 9'h12), 8'(8'h40 + b));
        do_write(10'h092, 8'h99);
        for (int b = 0; b < 4; b++) begin
            do_read(10'((b << 7) | 9'h12), g);
            check("R9 isolation", g, {1'b1, (b == 1) ? 8'h99 : 8'(8'h40 + b)});
        end
    endtask

    task automatic t_rom_read;
        logic [8:0] g;
        logic [9:0] pts [4] = '{10'h200, 10'h2A7, 10'h300, 10'h3FF};
        for (int i = 0; i < 4; i++) begin
            do_read(pts[i], g);
            check("R7 rom byte", g, {1'b1, exp_rom(pts[i][8:0])});
        end
    endtask

    task automatic t_rom_write_ignored;
        logic [8:0] g;
        do_write(10'h212, 8'h5C);
        do_read(10'h212, g); check("R8 rom unchanged", g, {1'b1, exp_rom(9'h012)});
        for (int b = 0; b < 4; b++) begin
            do_read(10'((b << 7) | 9'h12), g);
            check("R8 ram unchanged", g, {1'b1, (b == 1) ? 8'h99 : 8'(8'h40 + b)});
        end
    endtask

    task automatic t_read_priority;
        logic [8:0] g;
        @(negedge clk);
        addr = 10'h000; rd = 1'b1; wr = 1'b1; wdata = 8'h77;
        #1 check("R3 read with wr", {rd_valid, rd_data}, {1'b1, 8'hA1});
        @(negedge clk);
        rd = 1'b0; wr = 1'b0;
        do_read(10'h000, g); check("R3 no write", g, {1'b1, 8'hA1});
    endtask

    task automatic t_idle;
        logic [8:0] g;
        @(negedge clk);
        addr = 10'h07F; rd = 1'b0; wr = 1'b0; wdata = 8'h11;
        #1 check("R5 idle no valid", {rd_valid, rd_data}, 9'h000);
        @(negedge clk);
        addr = 10'h300;
        #1 check("R6 idle rom zone", {rd_valid, rd_data}, 9'h000);
        do_read(10'h07F, g); check("R5 no write", g, {1'b1, 8'hB2});
    endtask

    task automatic t_reset_write;
        logic [8:0] g;
        do_write(10'h105, 8'h11);
        @(negedge clk); rst = 1'b1;
        do_write(10'h105, 8'hEE);
        @(negedge clk); rst = 1'b0;
        do_read(10'h105, g); check("R10 write in reset", g, {1'b1, 8'h11});
    endtask

    initial begin
        t_reset_state();
        t_ram_rw();
        t_bank_isolation();
        t_rom_read();
        t_rom_write_ignored();
        t_read_priority();
        t_idle();
        t_reset_write();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule